// File: doc/BRIEF.md
# Breakpoint Address Comparator

This block is one hardware breakpoint channel for an on-chip debug unit. It watches a bus-cycle monitor port, one transfer per clock when the valid strobe is high, and raises a break request when a transfer meets every condition that software has programmed. The conditions are a break address, a per-bit address mask, and a condition register that picks the bus (local or internal), the access kind (instruction fetch or data), the direction (read or write) and the operand size.

Software programs the channel through a simple synchronous register port: a write strobe, a two-bit register select, write data and a combinational read-back path. The break request is a single registered pulse for each matching transfer. The exception handling that follows a break belongs to the consumer of that pulse.

Top module: `bkpt_channel`

## Requirements
- R1: After reset the address, mask and condition registers read as zero, `break_req` is low, and the channel raises no break.
- R2: Register select 0 holds the break address, select 1 holds the mask, and select 2 holds the condition register. A write lands on the clock edge where `reg_wr` is high. Address and mask keep only the low ADDR_W bits of the write data and read back zero-extended. Select 3 reads as zero and ignores writes.
- R3: The condition register uses bits 7:0. Bits 15:8 and every read-data bit above them read as 0, and writes to them are ignored.
- R4: The address condition holds when ((mon_addr XOR break address) AND NOT mask) is zero. A mask bit of 1 removes that address bit from the comparison.
- R5: Condition bits 1:0 select the bus. 00 disables the channel, so no break is ever raised. 01 and 11 match local-bus transfers (`mon_bus`=0). 10 matches internal-bus transfers (`mon_bus`=1).
- R6: Condition bits 3:2 select the access kind. 00 and 11 match any kind. 01 matches only instruction fetches (`mon_fetch`=1). 10 matches only data accesses (`mon_fetch`=0).
- R7: Condition bits 5:4 select the direction. 00 and 11 match either direction. 01 matches only reads (`mon_write`=0). 10 matches only writes (`mon_write`=1).
- R8: Condition bits 7:6 select the size. 00 matches any `mon_size`. 01 matches byte (`mon_size`=00), 10 matches halfword (01), and 11 matches word (10). A `mon_size` of 11 matches only under 00.
- R9: `break_req` is high for exactly the one cycle that follows a clock edge on which `mon_valid` was high and all conditions held. A transfer with `mon_valid` low never causes a break.
- R10: A transfer sampled on the same edge as a register write is compared against the settings held before that write. The new settings apply from the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 mask, 2 condition, 3 none |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Read data of the selected register, combinational |
| mon_valid | input | 1 | A bus transfer is present this cycle |
| mon_addr | input | ADDR_W (32) | Transfer address |
| mon_bus | input | 1 | 0 local bus, 1 internal bus |
| mon_fetch | input | 1 | 1 instruction fetch, 0 data access |
| mon_write | input | 1 | 1 write, 0 read |
| mon_size | input | 2 | 00 byte, 01 halfword, 10 word |
| break_req | output | 1 | One-cycle break request pulse |

## Verification
The assertions assume the monitor inputs are stable and defined around each rising edge, and that `reset` is held for at least one edge before any transfer. They also assume `reg_sel` is never left undefined while it is read. The bench drives every input on the falling edge, holds `mon_valid` low while reset is active, and always applies a full set of monitor fields with the strobe. Under these conditions the registered break request and the combinational read path are sampled only after they have settled.

// File: rtl/bkpt_pkg.sv
// Package bkpt_pkg
// Shared encodings for the breakpoint channel: register selects, the
// condition register layout and the bus-select codes.
// Assumes the condition register is 16 bits wide with its fields in bits 7:0.
package bkpt_pkg;

    localparam int COND_W      = 16;
    localparam int COND_USED_W = 8;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_MASK = 2'd1,
        SEL_COND = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        BUS_OFF       = 2'b00,
        BUS_LOCAL     = 2'b01,
        BUS_INTERNAL  = 2'b10,
        BUS_LOCAL_ALT = 2'b11
    } bus_sel_e;

    // Condition register bits 7:0, listed from MSB down.
    typedef struct packed {
        logic [1:0] size;   // 7:6
        logic [1:0] dir;    // 5:4
        logic [1:0] kind;   // 3:2
        logic [1:0] bus;    // 1:0
    } cond_t;

endpackage

// File: rtl/bkpt_regs.sv
// Module bkpt_regs
// Holds the break address, address mask and condition registers and
// provides the combinational read-back path.
// Assumes ADDR_W <= DATA_W. Reserved and unselected bits read as zero.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] mask_q,
    output cond_t             cond_q
);

    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    // Register update: a write to the selected register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
            cond_q <= '0;
        end else if (wr_en) begin
            case (sel_e)
                SEL_ADDR: addr_q <= wdata[ADDR_W-1:0];
                SEL_MASK: mask_q <= wdata[ADDR_W-1:0];
                SEL_COND: cond_q <= cond_t'(wdata[COND_USED_W-1:0]);
                default:  ;
            endcase
        end
    end

    // Read mux: zero-extends each register to the data width.
    always_comb begin
        rdata = '0;
        case (sel_e)
            SEL_ADDR: rdata[ADDR_W-1:0]      = addr_q;
            SEL_MASK: rdata[ADDR_W-1:0]      = mask_q;
            SEL_COND: rdata[COND_USED_W-1:0] = cond_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/bkpt_opt_match.sv
// Module bkpt_opt_match
// Decodes one two-option condition field: 00 and 11 accept either value,
// 01 accepts only attr=1 and 10 accepts only attr=0.
// Assumes attr is a single-bit attribute of the monitored transfer.
module bkpt_opt_match (
    input  logic [1:0] code,
    input  logic       attr,
    output logic       ok
);

    // Field decode.
    always_comb begin
        case (code)
            2'b01:   ok = attr;
            2'b10:   ok = !attr;
            default: ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/bkpt_match.sv
// Module bkpt_match
// Combinational comparison of one monitored transfer against the
// programmed address, mask and condition fields.
// Assumes the inputs are settled before the clock edge that samples hit.
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic              mon_bus,
    input  logic              mon_fetch,
    input  logic              mon_write,
    input  logic [1:0]        mon_size,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [ADDR_W-1:0] mask_q,
    input  cond_t             cond_q,
    output logic              hit
);

    localparam int N_OPT = 2;

    logic              addr_ok;
    logic              bus_ok;
    logic              size_ok;
    logic [N_OPT-1:0]  opt_ok;
    logic [N_OPT-1:0]  opt_attr;
    logic [1:0]        opt_code [N_OPT];
    logic [ADDR_W-1:0] diff;

    // Address compare: a differing bit counts only when it is not masked.
    always_comb begin
        diff    = (mon_addr ^ addr_q) & ~mask_q;
        addr_ok = (diff == '0);
    end

    // Bus select: 00 turns the channel off, and 11 behaves like 01.
    always_comb begin
        case (bus_sel_e'(cond_q.bus))
            BUS_LOCAL, BUS_LOCAL_ALT: bus_ok = !mon_bus;
            BUS_INTERNAL:             bus_ok = mon_bus;
            default:                  bus_ok = 1'b0;
        endcase
    end

    // Size select: 00 accepts any size; otherwise the code is size + 1.
    always_comb begin
        if (cond_q.size == 2'b00) size_ok = 1'b1;
        else                      size_ok = (mon_size == cond_q.size - 2'd1);
    end

    // Two-option fields: index 0 is the access kind, index 1 is the direction.
    always_comb begin
        opt_code[0] = cond_q.kind;
        opt_attr[0] = mon_fetch;
        opt_code[1] = cond_q.dir;
        opt_attr[1] = !mon_write;
    end

    for (genvar i = 0; i < N_OPT; i++) begin : g_opt
        bkpt_opt_match u_opt (
            .code (opt_code[i]),
            .attr (opt_attr[i]),
            .ok   (opt_ok[i])
        );
    end

    // Final hit: all conditions must hold.
    always_comb hit = addr_ok && bus_ok && size_ok && (&opt_ok);

endmodule

// File: rtl/bkpt_channel.sv
// Module bkpt_channel
// One breakpoint channel. It combines the register file with the match
// logic and registers a one-cycle break request for each matching valid
// transfer.
// Assumes a synchronous active-low reset. A transfer sampled on the same
// edge as a register write is compared against the old settings.
module bkpt_channel
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              mon_valid,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic              mon_bus,
    input  logic              mon_fetch,
    input  logic              mon_write,
    input  logic [1:0]        mon_size,
    output logic              break_req
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mask_q;
    cond_t             cond_q;
    logic              hit;

    bkpt_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .addr_q (addr_q),
        .mask_q (mask_q),
        .cond_q (cond_q)
    );

    bkpt_match #(
        .ADDR_W (ADDR_W)
    ) u_match (
        .mon_addr  (mon_addr),
        .mon_bus   (mon_bus),
        .mon_fetch (mon_fetch),
        .mon_write (mon_write),
        .mon_size  (mon_size),
        .addr_q    (addr_q),
        .mask_q    (mask_q),
        .cond_q    (cond_q),
        .hit       (hit)
    );

    // Break request register: a pulse for each valid matching transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) break_req <= 1'b0;
        else        break_req <= mon_valid && hit;
    end

endmodule

// File: rtl/bkpt_channel_chk.sv
// Module bkpt_channel_chk
// Property checker for bkpt_channel, attached through bind.
// Assumes the inputs are defined at each rising edge after reset.
module bkpt_channel_chk
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              mon_valid,
    input logic [ADDR_W-1:0] mon_addr,
    input logic              mon_bus,
    input logic              mon_fetch,
    input logic              mon_write,
    input logic              break_req,
    input logic [ADDR_W-1:0] addr_q,
    input logic [ADDR_W-1:0] mask_q,
    input cond_t             cond_q
);

    // R3: reserved bits of the condition register read as zero.
    p_cond_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd2) |-> (reg_rdata[DATA_W-1:COND_USED_W] == '0));

    // R2: the unused select reads as zero.
    p_none_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> (reg_rdata == '0));

    // R4: a break implies the unmasked address bits agreed on the previous edge.
    p_addr_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        break_req |-> ($past((mon_addr ^ addr_q) & ~mask_q) == '0));

    // R5: a disabled channel never breaks.
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_q.bus == 2'b00) |=> !break_req);

    // R5: internal-bus select rejects a local transfer.
    p_internal_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && cond_q.bus == 2'b10 && !mon_bus) |=> !break_req);

    // R6: fetch-only select rejects data accesses.
    p_fetch_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && cond_q.kind == 2'b01 && !mon_fetch) |=> !break_req);

    // R7: write-only select rejects reads.
    p_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && cond_q.dir == 2'b10 && !mon_write) |=> !break_req);

    // R9: a break request always follows a valid transfer.
    p_req_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        break_req |-> $past(mon_valid));

endmodule

bind bkpt_channel bkpt_channel_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .mon_valid (mon_valid),
    .mon_addr  (mon_addr),
    .mon_bus   (mon_bus),
    .mon_fetch (mon_fetch),
    .mon_write (mon_write),
    .break_req (break_req),
    .addr_q    (addr_q),
    .mask_q    (mask_q),
    .cond_q    (cond_q)
);

// File: tb/tb_bkpt_channel.sv
// Bench for bkpt_channel with a 4-bit address. It sweeps every address,
// mask and break-address combination, then every condition code against
// every transfer attribute, and compares against an arithmetic model.
module tb_bkpt_channel;

    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          mon_valid = 1'b0;
    logic [AW-1:0] mon_addr = '0;
    logic          mon_bus = 1'b0;
    logic          mon_fetch = 1'b0;
    logic          mon_write = 1'b0;
    logic [1:0]    mon_size = '0;
    logic          break_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bkpt_channel #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
        .mon_addr(mon_addr), .mon_bus(mon_bus), .mon_fetch(mon_fetch),
        .mon_write(mon_write), .mon_size(mon_size), .break_req(break_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Register write; starts and ends on a falling edge.
    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s; #1; d = reg_rdata;
    endtask

    // One monitored transfer; returns break_req in the following cycle.
    task automatic mon(input logic v, input logic [AW-1:0] a, input logic b,
                       input logic f, input logic w, input logic [1:0] sz,
                       output logic got);
        mon_valid = v; mon_addr = a; mon_bus = b; mon_fetch = f;
        mon_write = w; mon_size = sz;
        @(posedge clk); @(negedge clk);
        mon_valid = 1'b0;
        got = break_req;
    endtask

    function automatic logic opt_ok(input logic [1:0] c, input logic attr);
        if (c == 2'b01) return attr;
        if (c == 2'b10) return !attr;
        return 1'b1;
    endfunction

    function automatic logic model(input logic [7:0] c, input logic [AW-1:0] ba,
                                   input logic [AW-1:0] mk, input logic [AW-1:0] a,
                                   input logic b, input logic f, input logic w,
                                   input logic [1:0] sz);
        logic ok;
        ok = (((a ^ ba) & ~mk) == '0);                               // R4
        case (c[1:0])                                                // R5
            2'b01, 2'b11: ok = ok && !b;
            2'b10:        ok = ok && b;
            default:      ok = 1'b0;
        endcase
        ok = ok && opt_ok(c[3:2], f);                                // R6
        ok = ok && opt_ok(c[5:4], !w);                               // R7
        ok = ok && ((c[7:6] == 2'b00) || ({1'b0, sz} + 3'd1 == {1'b0, c[7:6]})); // R8
        return ok;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        got;

        repeat (3) @(negedge clk);
        check("R1 break_req in reset", {31'd0, break_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, d); check("R1 address after reset", d, 32'd0);
        rd(2'd1, d); check("R1 mask after reset", d, 32'd0);
        rd(2'd2, d); check("R1 condition after reset", d, 32'd0);
        mon(1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0, got);
        check("R1 disabled after reset", {31'd0, got}, 32'd0);

        // R2 / R3 register access
        wr(2'd0, 32'hFFFF_FFF5); rd(2'd0, d); check("R2 address readback", d, 32'h5);
        wr(2'd1, 32'h1234_567A); rd(2'd1, d); check("R2 mask readback", d, 32'hA);
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, d); check("R2 select 3 reads zero", d, 32'h0);
        rd(2'd0, d); check("R2 select 3 write ignored (address)", d, 32'h5);
        rd(2'd1, d); check("R2 select 3 write ignored (mask)", d, 32'hA);
        wr(2'd2, 32'hFFFF_FF5A); rd(2'd2, d); check("R3 reserved bits read zero", d, 32'h5A);

        // R4: every break address, mask and transfer address, local bus.
        wr(2'd2, 32'h01);
        for (int ba = 0; ba < 16; ba++) begin
            wr(2'd0, 32'(ba));
            for (int mk = 0; mk < 16; mk++) begin
                wr(2'd1, 32'(mk));
                for (int a = 0; a < 16; a++) begin
                    mon(1'b1, AW'(a), 1'b0, 1'b0, 1'b0, 2'd0, got);
                    check("R4 masked address compare", {31'd0, got},
                          {31'd0, model(8'h01, AW'(ba), AW'(mk), AW'(a), 1'b0, 1'b0, 1'b0, 2'd0)});
                end
            end
        end

        // R5..R8: every condition code against every attribute combination.
        wr(2'd0, 32'h3); wr(2'd1, 32'h0);
        for (int c = 0; c < 256; c++) begin
            wr(2'd2, 32'(c));
            for (int at = 0; at < 32; at++) begin
                logic b, f, w;
                logic [1:0] sz;
                b = at[0]; f = at[1]; w = at[2]; sz = 2'(at >> 3);
                mon(1'b1, 4'h3, b, f, w, sz, got);
                check("R5 R6 R7 R8 condition sweep", {31'd0, got},
                      {31'd0, model(8'(c), 4'h3, 4'h0, 4'h3, b, f, w, sz)});
            end
        end

        // R9: pulse shape and strobe qualification.
        wr(2'd2, 32'h01);
        mon(1'b1, 4'h3, 1'b0, 1'b0, 1'b0, 2'd0, got);
        check("R9 pulse on match", {31'd0, got}, 32'd1);
        mon(1'b0, 4'h3, 1'b0, 1'b0, 1'b0, 2'd0, got);
        check("R9 pulse lasts one cycle", {31'd0, got}, 32'd0);
        mon(1'b0, 4'h3, 1'b0, 1'b0, 1'b0, 2'd0, got);
        check("R9 no break without strobe", {31'd0, got}, 32'd0);

        // R10: write and transfer on the same edge use the old settings.
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h00;
        mon(1'b1, 4'h3, 1'b0, 1'b0, 1'b0, 2'd0, got);
        reg_wr = 1'b0;
        check("R10 old enabled setting used", {31'd0, got}, 32'd1);
        mon(1'b1, 4'h3, 1'b0, 1'b0, 1'b0, 2'd0, got);
        check("R10 new disabled setting applies", {31'd0, got}, 32'd0);
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h01;
        mon(1'b1, 4'h3, 1'b0, 1'b0, 1'b0, 2'd0, got);
        reg_wr = 1'b0;
        check("R10 old disabled setting used", {31'd0, got}, 32'd0);
        mon(1'b1, 4'h3, 1'b0, 1'b0, 1'b0, 2'd0, got);
        check("R10 new enabled setting applies", {31'd0, got}, 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule